// File: doc/BRIEF.md
# Externally Clocked Four-Channel FIFO Port

This block is a parallel port driven by outside logic. An external master uses it to push bytes or 16-bit words into one of four internal FIFOs and to pull them back out. A two-bit channel number picks the FIFO. An active-low select input enables the port. While the port is selected, the read strobe, write strobe, output enable and packet-end inputs act. While it is not selected, they do nothing. Each channel has its own width bit: 8-bit transfers move one byte and 16-bit transfers move two bytes, low byte first.

Written data sits in a pending region and cannot be read yet. It becomes readable when a packet-end pulse commits it. It is also committed automatically once the pending region reaches a set packet size. Read data shows the head of the selected channel, in first-word fall-through style, while the output enable is on. A read strobe moves past that head. A write attempted while the output enable is on is a bus conflict: the word is dropped and a one-cycle error pulse is raised.

The strobes work in one of two modes, chosen at run time:
- In clocked mode, each clock edge that sees a strobe high is one transfer.
- In pulse mode, the strobes first pass through a synchronizer. Each rising edge of a strobe then counts as exactly one transfer, however long the pulse lasts.

Top module: `sfp_port`

## Requirements
- R1: A synchronous active-low reset sets all four empty flags to 1, clears all full flags and clears the error pulse.
- R2: While the active-low select is high, the write, read, packet-end and output-enable inputs have no effect: nothing is stored and read data stays zero.
- R3: The two-bit channel input picks the FIFO. Data written to one channel never shows up in another.
- R4: For a channel whose width bit is 0, each write stores wrData[7:0]. Read data is {8'h00, head byte}, and each read consumes one byte.
- R5: For a channel whose width bit is 1, each write stores wrData[7:0] and then wrData[15:8]. A read returns both bytes, with the older byte in bits 7:0, and consumes two bytes.
- R6: Read data is zero whenever the output enable is low, the select is high, or the selected channel has no committed data.
- R7: Written bytes stay invisible, and the empty flag stays 1, until a packet-end pulse on that channel or until the pending bytes reach PKT_BYTES.
- R8: A write presented while the output enable is on stores nothing. It raises the error output for exactly the next cycle.
- R9: A channel's full flag is 1 when its free space is smaller than one transfer (1 byte or 2 bytes). A write to a full channel is ignored, and so is a read from an empty channel.
- R10: In clocked mode (asyncMode = 0), every clock edge that sees a strobe high performs one transfer.
- R11: In pulse mode (asyncMode = 1), each strobe pulse performs exactly one transfer, whatever its length.
- R12: Each channel returns bytes in the order they were written, including across the wrap of its storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Synchronous reset, active low |
| asyncMode | input | 1 | 1 = strobes act as pulses, 0 = strobes qualify the clock |
| wideCfg | input | 4 | Per-channel width bit, 1 = 16-bit transfers |
| csN | input | 1 | Port select, active low |
| fifoSel | input | 2 | Channel number |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| oeEn | input | 1 | Output enable for read data |
| pktEnd | input | 1 | Commit the pending packet of the selected channel |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Head of the selected channel, or zero |
| emptyFlag | output | 4 | Per channel: no committed data |
| fullFlag | output | 4 | Per channel: no room for one transfer |
| protoErr | output | 1 | One-cycle pulse after a write that collided with the output enable |

## Verification
The bench runs each channel through several patterns:
- Byte bursts with channel-specific values. These separate channels from each other and show that the upper write byte is dropped in 8-bit mode.
- Words whose two bytes differ. These show the byte order in 16-bit mode.
- Fills to exactly full, then drains. These exercise the full boundary and storage wrap, both for bytes and for words.

Other stimuli target specific rules:
- Pending-data visibility is checked just below and at the automatic commit size.
- A strobe held for several clocks is run in both modes. It counts three transfers in clocked mode and one per pulse in pulse mode.
- Strobes with the port deselected, and writes that collide with the output enable, must leave the channel empty.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int NUM_FIFOS = 4;
  localparam int SEL_W     = $clog2(NUM_FIFOS);

  // Qualified per-cycle actions handed from control to datapath.
  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             commit;
    logic [SEL_W-1:0] sel;
  } xfer_strobe_t;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asyncMode,
  input  logic             csN,
  input  logic [SEL_W-1:0] fifoSel,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic             oeEn,
  input  logic             pktEnd,
  output xfer_strobe_t     xfer,
  output logic             protoErr
);
  localparam int NSTB = 3;  // bit 0 read, bit 1 write, bit 2 packet end

  logic [NSTB-1:0] rawStb;
  logic [NSTB-1:0] syncQ [SYNC_STAGES];
  logic [NSTB-1:0] prevQ;
  logic [NSTB-1:0] edgeStb;
  logic [NSTB-1:0] actStb;
  logic            selected;
  logic            oeActive;
  logic            wrAttempt;

  assign rawStb = {pktEnd, wrStb, rdStb};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ    <= '0;
      protoErr <= 1'b0;
    end else begin
      syncQ[0] <= rawStb;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ    <= syncQ[SYNC_STAGES-1];
      protoErr <= wrAttempt && oeActive;
    end
  end

  always_comb begin
    edgeStb     = syncQ[SYNC_STAGES-1] & ~prevQ;
    actStb      = asyncMode ? edgeStb : rawStb;
    selected    = !csN;
    oeActive    = selected && oeEn;
    wrAttempt   = selected && actStb[1];
    xfer.wr     = wrAttempt && !oeActive;
    xfer.rd     = selected && actStb[0];
    xfer.commit = selected && actStb[2];
    xfer.sel    = fifoSel;
  end
endmodule

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int PKT_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FIFOS-1:0] wideCfg,
  input  xfer_strobe_t         xfer,
  input  logic                 oeOn,
  input  logic [15:0]          wrData,
  output logic [15:0]          rdData,
  output logic [NUM_FIFOS-1:0] emptyFlag,
  output logic [NUM_FIFOS-1:0] fullFlag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    headLo [NUM_FIFOS];
  logic [7:0]    headHi [NUM_FIFOS];
  logic [CW-1:0] cmtArr [NUM_FIFOS];

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : gFifo
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wrPtr, rdPtr;
    logic [CW-1:0] cmtCnt, pendCnt, freeCnt, xferBytes, wrBytes, rdBytes, pendAfter;
    logic          hit, flush;

    always_comb begin
      hit       = xfer.sel == SEL_W'(g);
      xferBytes = wideCfg[g] ? CW'(2) : CW'(1);
      freeCnt   = CW'(DEPTH) - cmtCnt - pendCnt;
      wrBytes   = (hit && xfer.wr && freeCnt >= xferBytes) ? xferBytes : '0;
      rdBytes   = '0;
      if (hit && xfer.rd && cmtCnt != '0)
        rdBytes = (wideCfg[g] && cmtCnt >= CW'(2)) ? CW'(2) : CW'(1);
      pendAfter = pendCnt + wrBytes;
      flush     = (hit && xfer.commit) || pendAfter >= CW'(PKT_BYTES);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        cmtCnt  <= '0;
        pendCnt <= '0;
      end else begin
        wrPtr <= wrPtr + AW'(wrBytes);
        rdPtr <= rdPtr + AW'(rdBytes);
        if (flush) begin
          cmtCnt  <= cmtCnt - rdBytes + pendAfter;
          pendCnt <= '0;
        end else begin
          cmtCnt  <= cmtCnt - rdBytes;
          pendCnt <= pendAfter;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (wrBytes != '0) begin
        mem[wrPtr] <= wrData[7:0];
        if (wideCfg[g]) mem[wrPtr + AW'(1)] <= wrData[15:8];
      end
    end

    assign headLo[g]    = mem[rdPtr];
    assign headHi[g]    = mem[rdPtr + AW'(1)];
    assign cmtArr[g]    = cmtCnt;
    assign emptyFlag[g] = cmtCnt == '0;
    assign fullFlag[g]  = freeCnt < xferBytes;
  end

  always_comb begin
    rdData = '0;
    if (oeOn && cmtArr[xfer.sel] != '0) begin
      rdData[7:0] = headLo[xfer.sel];
      if (wideCfg[xfer.sel] && cmtArr[xfer.sel] >= CW'(2))
        rdData[15:8] = headHi[xfer.sel];
    end
  end
endmodule

// File: rtl/sfp_port.sv
module sfp_port #(
  parameter int DEPTH       = 512,
  parameter int PKT_BYTES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          asyncMode,
  input  logic [sfp_pkg::NUM_FIFOS-1:0] wideCfg,
  input  logic                          csN,
  input  logic [sfp_pkg::SEL_W-1:0]     fifoSel,
  input  logic                          rdStb,
  input  logic                          wrStb,
  input  logic                          oeEn,
  input  logic                          pktEnd,
  input  logic [15:0]                   wrData,
  output logic [15:0]                   rdData,
  output logic [sfp_pkg::NUM_FIFOS-1:0] emptyFlag,
  output logic [sfp_pkg::NUM_FIFOS-1:0] fullFlag,
  output logic                          protoErr
);
  sfp_pkg::xfer_strobe_t xfer;
  logic                  oeOn;

  assign oeOn = !csN && oeEn;

  sfp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .csN(csN), .fifoSel(fifoSel),
    .rdStb(rdStb), .wrStb(wrStb), .oeEn(oeEn), .pktEnd(pktEnd),
    .xfer(xfer), .protoErr(protoErr)
  );

  sfp_datapath #(.DEPTH(DEPTH), .PKT_BYTES(PKT_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .wideCfg(wideCfg), .xfer(xfer), .oeOn(oeOn),
    .wrData(wrData), .rdData(rdData), .emptyFlag(emptyFlag), .fullFlag(fullFlag)
  );
endmodule

// File: rtl/sfp_port_chk.sv
module sfp_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        oeEn,
  input logic [15:0] rdData,
  input logic [3:0]  emptyFlag,
  input logic [3:0]  fullFlag,
  input logic        protoErr
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (emptyFlag == 4'hF && fullFlag == 4'h0 && !protoErr));

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(emptyFlag));

  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !oeEn) |-> rdData == 16'h0);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(!csN && oeEn));
endmodule

bind sfp_port sfp_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .oeEn(oeEn), .rdData(rdData),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag), .protoErr(protoErr)
);

// File: tb/sfp_port_tb.sv
module sfp_port_tb;
  logic        clk = 0, rstN = 0, asyncMode = 0, csN = 1;
  logic        rdStb = 0, wrStb = 0, oeEn = 0, pktEnd = 0;
  logic [3:0]  wideCfg = 0;
  logic [1:0]  fifoSel = 0;
  logic [15:0] wrData = 0, rdData;
  logic [3:0]  emptyFlag, fullFlag;
  logic        protoErr;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sfp_port #(.DEPTH(16), .PKT_BYTES(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .wideCfg(wideCfg), .csN(csN),
    .fifoSel(fifoSel), .rdStb(rdStb), .wrStb(wrStb), .oeEn(oeEn), .pktEnd(pktEnd),
    .wrData(wrData), .rdData(rdData), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .protoErr(protoErr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  task automatic wrOne(int f, logic [15:0] d);
    @(negedge clk); csN = 0; fifoSel = 2'(f); wrData = d; wrStb = 1;
    @(negedge clk); wrStb = 0; csN = 1;
  endtask

  task automatic commitOne(int f);
    @(negedge clk); csN = 0; fifoSel = 2'(f); pktEnd = 1;
    @(negedge clk); pktEnd = 0; csN = 1;
  endtask

  task automatic popCheck(int f, logic [15:0] exp, string tag);
    @(negedge clk); csN = 0; fifoSel = 2'(f); oeEn = 1;
    #1 check(tag, rdData, exp);
    rdStb = 1;
    @(negedge clk); rdStb = 0; oeEn = 0; csN = 1;
  endtask

  // pulse-mode strobe: 0 read, 1 write, 2 packet end
  task automatic pulseOne(int which, int f, logic [15:0] d);
    @(negedge clk); csN = 0; fifoSel = 2'(f); wrData = d;
    case (which) 0: rdStb = 1; 1: wrStb = 1; default: pktEnd = 1; endcase
    repeat (5) @(negedge clk);
    rdStb = 0; wrStb = 0; pktEnd = 0;
    repeat (5) @(negedge clk);
    csN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", emptyFlag, 4'hF);
    check("R1 full", fullFlag, 4'h0);
    check("R1 err", protoErr, 0);

    // R2 deselected strobes do nothing
    @(negedge clk); csN = 1; fifoSel = 0; wrData = 16'h55; wrStb = 1; pktEnd = 1;
    @(negedge clk); wrStb = 0; pktEnd = 0;
    commitOne(0);
    check("R2 write ignored", emptyFlag[0], 1);
    @(negedge clk); csN = 1; oeEn = 1;
    #1 check("R2 rdData idle", rdData, 0);
    oeEn = 0;

    // R3 R4 R7 R12 byte sweep on every channel
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 5; k++) wrOne(f, 16'hBE00 | 16'(f * 16 + k));
      check("R7 pending hidden", emptyFlag, 4'hF);
      commitOne(f);
      check("R3 only selected", emptyFlag, 4'hF & ~(4'h1 << f));
      for (int k = 0; k < 5; k++) popCheck(f, 16'(f * 16 + k), "R4 byte read");
      check("R12 drained", emptyFlag, 4'hF);
    end

    // R7 automatic commit at packet size
    for (int k = 0; k < 7; k++) wrOne(1, 16'(8'h40 + k));
    check("R7 below size", emptyFlag[1], 1);
    wrOne(1, 16'h47);
    check("R7 at size", emptyFlag[1], 0);
    for (int k = 0; k < 8; k++) popCheck(1, 16'(8'h40 + k), "R7 auto data");

    // R5 word mode
    wideCfg = 4'b0100;
    for (int k = 0; k < 3; k++) wrOne(2, {8'(8'hC0 + k), 8'(8'h30 + k)});
    commitOne(2);
    for (int k = 0; k < 3; k++) popCheck(2, {8'(8'hC0 + k), 8'(8'h30 + k)}, "R5 word read");
    check("R5 empty", emptyFlag[2], 1);

    // R9 R12 byte fill to full, with wrap
    for (int k = 0; k < 16; k++) wrOne(3, 16'(8'h80 + k));
    check("R9 full bytes", fullFlag[3], 1);
    wrOne(3, 16'h00FF);
    for (int k = 0; k < 16; k++) popCheck(3, 16'(8'h80 + k), "R12 order");
    check("R9 empty after drain", emptyFlag[3], 1);
    popCheck(3, 16'h0, "R9 empty read zero");
    check("R9 empty read ignored", emptyFlag[3], 1);
    check("R9 not full", fullFlag[3], 0);

    // R9 word fill to full, with wrap
    for (int k = 0; k < 8; k++) wrOne(2, {8'(8'hD0 + k), 8'(8'h10 + k)});
    check("R9 full words", fullFlag[2], 1);
    wrOne(2, 16'hEEEE);
    for (int k = 0; k < 8; k++) popCheck(2, {8'(8'hD0 + k), 8'(8'h10 + k)}, "R9 word order");
    check("R9 words drained", emptyFlag[2], 1);
    wideCfg = 4'b0000;

    // R6 read data gating
    wrOne(0, 16'h00A5); commitOne(0);
    @(negedge clk); csN = 0; fifoSel = 0; oeEn = 0;
    #1 check("R6 oe low", rdData, 0);
    csN = 1; oeEn = 1;
    #1 check("R6 cs high", rdData, 0);
    oeEn = 0;
    popCheck(0, 16'h00A5, "R6 data kept");

    // R8 write during output enable
    @(negedge clk); csN = 0; fifoSel = 0; oeEn = 1; wrData = 16'h77; wrStb = 1;
    @(negedge clk); check("R8 err pulse", protoErr, 1); wrStb = 0; oeEn = 0;
    @(negedge clk); check("R8 err clears", protoErr, 0); csN = 1;
    commitOne(0);
    check("R8 discarded", emptyFlag[0], 1);

    // R10 held strobe in clocked mode = one transfer per edge
    @(negedge clk); csN = 0; fifoSel = 1; wrData = 16'h9A; wrStb = 1;
    repeat (3) @(negedge clk);
    wrStb = 0; csN = 1;
    commitOne(1);
    for (int k = 0; k < 3; k++) popCheck(1, 16'h9A, "R10 per edge");
    check("R10 exactly three", emptyFlag[1], 1);

    // R11 pulse mode = one transfer per pulse
    asyncMode = 1;
    for (int k = 0; k < 3; k++) pulseOne(1, 1, 16'(8'h61 + k));
    check("R11 pending hidden", emptyFlag[1], 1);
    pulseOne(2, 1, 0);
    check("R11 committed", emptyFlag[1], 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); csN = 0; fifoSel = 1; oeEn = 1;
      #1 check("R11 head", rdData, 16'(8'h61 + k));
      oeEn = 0;
      pulseOne(0, 1, 0);
    end
    check("R11 one per pulse", emptyFlag[1], 1);

    finishRun();
  end
endmodule